// File: doc/BRIEF.md
# Bidirectional Two-Group Round-Robin Arbiter

This block grants one output port to at most one of N requesting crosspoints per cell period, with round-robin fairness. The decision is not made by a central priority encoder. It is made by a chain of identical crosspoint cells, and each cell looks only at its own request, its own group flag and three chained levels.

The crosspoints are split in two groups at the last grant. The low group runs from index 0 up to and including the last granted index. The high group is everything after it.

- Two downstream levels run through the chain. One locates the first requester of the low group, and the other locates the first requester of the high group.
- One upstream level tells every cell whether any high-group crosspoint below it is requesting.
- A requesting high-group crosspoint always wins. A low-group crosspoint wins only when the high group is silent.

The acknowledge is combinational within the cell period. On the period strobe, every cell computes its own next group flag from the same levels. The register bank then moves the boundary to just after the winner.

Top module: `rr_bidir_arbiter`

## Requirements
- R1: `ack_o` has at most one bit set, and any set bit is also set in `req_i`.
- R2: Whenever `req_i` is nonzero, exactly one acknowledge bit is set.
- R3: If any crosspoint with its `hi_mask_o` bit set (group high) is requesting, the acknowledge goes to the lowest-index requester among those crosspoints.
- R4: If only crosspoints with their `hi_mask_o` bit clear (group low) are requesting, the acknowledge goes to the lowest-index requester among them.
- R5: On a clock edge with `period_i` high and a grant at index p, `hi_mask_o` becomes bits p+1..N-1 set and bits 0..p clear. A grant at index N-1 therefore clears the whole mask.
- R6: On a clock edge with `period_i` high and `req_i` zero, `hi_mask_o` keeps its value.
- R7: On a clock edge with `period_i` low, `hi_mask_o` keeps its value whatever `req_i` holds.
- R8: After reset, `hi_mask_o` is all ones, which makes index 0 the first in line.
- R9: Over any sequence of periods, the acknowledged index equals that of an ideal round-robin arbiter. That arbiter starts its scan one place after the last index granted on a strobe, wraps around from N-1 to 0, and starts at index 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | 1 | Cell-period strobe; commits the new group boundary |
| req_i | input | N | Request per crosspoint, bit i is crosspoint i, index 0 scanned first |
| ack_o | output | N | One-hot acknowledge, combinational from `req_i` and the group state |
| hi_mask_o | output | N | Group flags, bit i set means crosspoint i is in the high group |

## Verification
The bench builds the arbiter with N = 8. At that size, the boundary can sit at every interior position as well as at both ends. An all-low mask is reached by a grant at index 7, and a later grant at index 0 makes the wrap-around visible.

Directed periods set up the following cases:
- a high-group request racing a low-group request;
- low-only requests;
- periods without a strobe;
- strobes with no request.

Several thousand random periods, with request densities ranging from sparse to full, are then compared with a behavioural round-robin pointer model.

// File: rtl/rr_bidir_pkg.sv
package rr_bidir_pkg;

   // Levels travelling from crosspoint i to crosspoint i+1.
   // lo_free: no low-group requester seen yet above this point.
   // hi_free: no high-group requester seen yet above this point.
   typedef struct packed {
      logic lo_free;
      logic hi_free;
   } dn_bus_t;

   localparam dn_bus_t DN_HEAD = '{lo_free: 1'b1, hi_free: 1'b1};

   // The upstream level entering the bottom cell: nothing lies below it.
   localparam logic UP_TAIL = 1'b0;

   // Group flag value taken at reset: every crosspoint in the high group.
   localparam logic GROUP_RESET = 1'b1;

endpackage

// File: rtl/rr_bidir_xpcell.sv
module rr_bidir_xpcell
   import rr_bidir_pkg::*;
(
   input  logic    req_i,
   input  logic    hi_i,
   input  dn_bus_t dn_i,
   input  logic    up_i,
   output dn_bus_t dn_o,
   output logic    up_o,
   output logic    ack_o,
   output logic    hi_nxt_o
);

   logic lo_req;
   logic hi_req;
   logic lo_hit;
   logic hi_hit;

   assign lo_req = req_i & ~hi_i;
   assign hi_req = req_i &  hi_i;

   // Each downstream level is taken by the first requester of its group.
   assign lo_hit = lo_req & dn_i.lo_free;
   assign hi_hit = hi_req & dn_i.hi_free;

   assign dn_o.lo_free = dn_i.lo_free & ~lo_req;
   assign dn_o.hi_free = dn_i.hi_free & ~hi_req;

   // Upstream level: some high-group crosspoint at or below this one requests.
   assign up_o = up_i | hi_req;

   // A low-group hit is suppressed while the high group has a request.
   // Every high-group cell lies below every low-group cell, so up_i
   // carries the whole high group for a low-group cell.
   assign ack_o = hi_hit | (lo_hit & ~up_i);

   // Next flag: set exactly when this period's grant lies strictly above
   // this cell. With no request anywhere, the current flag is kept.
   always_comb begin
      if (hi_i) begin
         // Grant above in the high group, or no high request at all
         // (the grant is then in the low group above, or there is none).
         hi_nxt_o = ~dn_i.hi_free | (~req_i & ~up_i);
      end else begin
         // A low-group grant above, with the high group silent.
         hi_nxt_o = ~up_i & ~dn_i.lo_free;
      end
   end

endmodule

// File: rtl/rr_bidir_grpreg.sv
module rr_bidir_grpreg
   import rr_bidir_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] nxt_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rr_bidir_grpreg: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q_o[b] <= GROUP_RESET;
         end else if (load_i) begin
            q_o[b] <= nxt_i[b];
         end
      end
   end

endmodule

// File: rtl/rr_bidir_arbiter.sv
module rr_bidir_arbiter
   import rr_bidir_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         period_i,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] ack_o,
   output logic [N-1:0] hi_mask_o
);

   localparam int LINKS = N + 1;

   generate
      if (N < 2) begin : g_bad_n
         $error("rr_bidir_arbiter: N must be at least 2");
      end
   endgenerate

   dn_bus_t        dn_link [LINKS];
   logic [N:0]     up_link;
   logic [N-1:0]   hi_q;
   logic [N-1:0]   hi_nxt;

   // Boundary conditions at both ends of the chain.
   assign dn_link[0] = DN_HEAD;
   assign up_link[N] = UP_TAIL;

   for (genvar i = 0; i < N; i++) begin : g_xp
      rr_bidir_xpcell u_cell (
         .req_i    (req_i[i]),
         .hi_i     (hi_q[i]),
         .dn_i     (dn_link[i]),
         .up_i     (up_link[i+1]),
         .dn_o     (dn_link[i+1]),
         .up_o     (up_link[i]),
         .ack_o    (ack_o[i]),
         .hi_nxt_o (hi_nxt[i])
      );
   end

   rr_bidir_grpreg #(.WIDTH(N)) u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (period_i),
      .nxt_i  (hi_nxt),
      .q_o    (hi_q)
   );

   assign hi_mask_o = hi_q;

   // Chain tails that feed no cell are deliberately left open.
   logic unused_tail;
   assign unused_tail = ^{dn_link[N], up_link[0]};

endmodule

// File: rtl/rr_bidir_arbiter_chk.sv
module rr_bidir_arbiter_chk #(
   parameter int N = 8
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         period_i,
   input logic [N-1:0] req_i,
   input logic [N-1:0] ack_o,
   input logic [N-1:0] hi_mask_o
);

   p_ack_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ack_o));

   p_ack_requested_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o & ~req_i) == '0);

   p_work_conserving_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i != '0) |-> ($countones(ack_o) == 1));

   p_high_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((req_i & hi_mask_o) != '0) |-> ((ack_o & hi_mask_o) != '0));

   p_low_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((req_i & hi_mask_o) == '0) && (req_i != '0)) |-> ((ack_o & ~hi_mask_o) != '0));

   p_boundary_move_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_i && (ack_o != '0)) |=> (hi_mask_o == ~(($past(ack_o) << 1) - 1'b1)));

   p_mask_suffix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((hi_mask_o << 1) & ~hi_mask_o) == '0));

   p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_i && (req_i == '0)) |=> $stable(hi_mask_o));

   p_no_strobe_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!period_i) |=> $stable(hi_mask_o));

endmodule

bind rr_bidir_arbiter rr_bidir_arbiter_chk #(.N(N)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .period_i  (period_i),
   .req_i     (req_i),
   .ack_o     (ack_o),
   .hi_mask_o (hi_mask_o)
);

// File: tb/rr_bidir_arbiter_test.sv
module rr_bidir_arbiter_test;

   localparam int N = 8;

   logic         clk;
   logic         rst_n;
   logic         period;
   logic [N-1:0] req;
   logic [N-1:0] ack;
   logic [N-1:0] mask;

   int n_checks = 0;
   int n_fails  = 0;
   int last_idx = -1;
   bit finished = 0;

   rr_bidir_arbiter #(.N(N)) uut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .period_i  (period),
      .req_i     (req),
      .ack_o     (ack),
      .hi_mask_o (mask)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   function automatic logic [N-1:0] model_ack(logic [N-1:0] r, int last);
      logic [N-1:0] a = '0;
      for (int k = 1; k <= N; k++) begin
         int idx = (last + k + N) % N;
         if (r[idx] && a == '0) a[idx] = 1'b1;
      end
      return a;
   endfunction

   function automatic logic [N-1:0] model_mask(int last);
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) m[i] = (i > last);
      return m;
   endfunction

   function automatic int index_of(logic [N-1:0] a);
      for (int i = 0; i < N; i++) if (a[i]) return i;
      return -1;
   endfunction

   task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b (req %b)", tag, act, exp, req);
      end
   endtask

   // One cell period: drive after the falling edge, then compare.
   task automatic period_step(logic [N-1:0] r, logic s, string mtag);
      logic [N-1:0] ea;
      string atag;
      @(negedge clk);
      req    = r;
      period = s;
      #1;
      check(mtag, mask, model_mask(last_idx));
      ea = model_ack(r, last_idx);
      if (r == '0)                          atag = "R2";
      else if ((r & model_mask(last_idx)) != '0) atag = "R3";
      else                                  atag = "R4";
      check(atag, ack, ea);
      n_checks++;
      if ($countones(ack) > 1 || (ack & ~r) != '0) begin
         n_fails++;
         $display("FAIL R1: actual %b expected onehot subset of %b", ack, r);
      end
      if (s && r != '0) last_idx = index_of(ea);
   endtask

   initial begin
      int seed;
      seed   = $urandom(32'd20240611);
      rst_n  = 1'b0;
      period = 1'b0;
      req    = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: reset state
      check("R8", mask, '1);
      period_step(8'b0000_0110, 1'b1, "R8");
      // Grant at 1: mask 1111_1100; low-only requests
      period_step(8'b0000_0011, 1'b0, "R5");
      // High request racing a low request: index 7 wins
      period_step(8'b1000_0011, 1'b1, "R5");
      // Mask now all low: lowest requester wins, R4 wrap to 0
      period_step(8'b1000_0001, 1'b0, "R5");
      // No strobe: the mask is held
      period_step(8'b0001_0000, 1'b0, "R7");
      // Strobe with no request: the mask is held
      period_step(8'b0000_0000, 1'b1, "R7");
      period_step(8'b1010_0000, 1'b1, "R6");
      // Grant at 5; then all request
      period_step(8'b1111_1111, 1'b1, "R5");
      period_step(8'b1111_1111, 1'b1, "R5");
      // R9: random periods against the ideal round-robin model
      for (int t = 0; t < 4000; t++) begin
         logic [N-1:0] r;
         int dens;
         dens = $urandom_range(0, 3);
         r = N'($urandom);
         if (dens == 0) r = r & N'($urandom) & N'($urandom);
         else if (dens == 3) r = r | N'($urandom);
         period_step(r, ($urandom_range(0, 3) != 0), "R9");
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule